// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block derives a one-cycle enable pulse from the system clock. On average the pulse occurs once every `INT + FRAC/256` cycles. The divisor is a 16-bit integer part plus an 8-bit fraction. Logic that should advance at a slower rate qualifies its registers with the pulse. The output is an enable, not a clock, so every consumer stays in the system clock domain.

Each period lasts either `INT` or `INT + 1` cycles. An 8-bit phase accumulator adds the fraction once per period. When that addition carries out, the period it starts gets one extra cycle, so the fractional error is spread evenly over the output sequence. A down counter measures each period. The divisor inputs are sampled only when a period begins.

A small controller has two states. `ST_EDGE` means the counter has reached the last cycle of a period, and the pulse fires if the divider is running. `ST_WAIT` means cycles of the period are still outstanding. Its transitions are:

- `EDGE_HOLD`: `ST_EDGE` to `ST_EDGE` when the new period is one cycle long.
- `EDGE_START`: `ST_EDGE` to `ST_WAIT` when the new period is longer.
- `WAIT_COUNT`: `ST_WAIT` to `ST_WAIT` while more than one cycle remains.
- `WAIT_DONE`: `ST_WAIT` to `ST_EDGE` when the final cycle is reached.
- `RESTART`: from either state, the restart strobe starts a fresh period at once, and the next state follows from that period's length.

Top module: `fdiv_top`

## Requirements
- R1: With a zero fraction and a running divider, consecutive pulses are exactly `INT` cycles apart. Each pulse is one cycle wide, except that `INT = 1` with a zero fraction pulses on every cycle.
- R2: An integer input of 0 selects a divisor integer part of 65536.
- R3: With a constant divisor, the n-th pulse after a restart comes `n*INT + floor(n*FRAC/256)` cycles after the restart cycle. Every period is therefore `INT` or `INT + 1` cycles, and 256 pulses span exactly `256*INT + FRAC` cycles.
- R4: After reset the phase is at the end of a period and the accumulator is zero. The first cycle with `run_i` high pulses, whatever the divisor. The next pulse follows `INT` cycles later when the fraction is zero.
- R5: While `run_i` is low, no pulse is produced and the counter and accumulator hold. On resuming, the interrupted period completes with only its remaining cycles.
- R6: A cycle with `restart_i` high produces no pulse, clears the accumulator, and starts a new period of `INT` cycles. The first pulse then falls `INT` running cycles later. This applies in any state and even while `run_i` is low.
- R7: The divisor inputs are sampled only in a pulse cycle or a restart cycle. A change in the middle of a period alters only the periods that begin afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Global enable; low freezes the divider |
| restart_i | input | 1 | Phase restart strobe, one cycle |
| div_int_i | input | 16 | Integer part of the divisor (0 means 65536) |
| div_frac_i | input | 8 | Fractional part of the divisor, in 1/256 steps |
| tick_o | output | 1 | One-cycle enable pulse |

## Verification
The assertions check, on every cycle, the properties that depend only on the current state:

- The pulse is silent while halted or restarting.
- The counter and accumulator hold when the divider is frozen.
- The counter steps down by exactly one within a period.
- The accumulator changes only at a period boundary.
- A pulse only ever coincides with a zero count.

Only the bench scenarios can show the long-run spacing of pulses. These include:

- the closed-form arrival time of each pulse for several fractions;
- the 256-pulse total;
- the 65536-cycle period selected by a zero integer;
- resumption of a paused period;
- the moment at which a changed divisor takes effect.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Controller states: ST_EDGE = last cycle of a period, ST_WAIT = cycles outstanding
    typedef enum logic [0:0] {
        ST_EDGE = 1'b0,
        ST_WAIT = 1'b1
    } fdiv_state_e;

endpackage

// File: rtl/fdiv_len_calc.sv
// Computes (period length - 1) from the integer part and the accumulator carry.
// An integer of 0 wraps to all-ones after the decrement, giving a 2^INT_W period.
module fdiv_len_calc #(
    parameter int INT_W = 16
) (
    input  logic [INT_W-1:0] div_int_i,
    input  logic             carry_i,
    output logic [INT_W:0]   len_m1_o
);

    logic [INT_W-1:0] int_m1;

    always_comb begin
        int_m1   = div_int_i - INT_W'(1);
        len_m1_o = {1'b0, int_m1} + {{INT_W{1'b0}}, carry_i};
    end

endmodule

// File: rtl/fdiv_phase_acc.sv
// Fractional phase accumulator; adds the fraction once per period start.
module fdiv_phase_acc #(
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] acc_o,
    output logic              carry_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] base;
    logic [FRAC_W:0]   sum;

    always_comb begin
        base    = clear_i ? '0 : acc_q;
        sum     = {1'b0, base} + {1'b0, frac_i};
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (load_i) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/fdiv_down_cnt.sv
// Period down counter: loads (length - 1), steps down to zero.
module fdiv_down_cnt #(
    parameter int W = 17
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         dec_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         is_one_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign is_one_o = (cnt_q == W'(1));

endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              tick_o
);

    import fdiv_pkg::*;

    localparam int CNT_W = INT_W + 1;

    fdiv_state_e       state_q;
    fdiv_state_e       state_d;
    logic              period_load;
    logic              cnt_dec;
    logic              carry;
    logic              cnt_is_one;
    logic [CNT_W-1:0]  len_m1;
    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;

    // A new period begins on a pulse cycle or on a restart
    assign period_load = restart_i | (run_i & (state_q == ST_EDGE));
    assign cnt_dec     = run_i & ~restart_i & (state_q == ST_WAIT);

    fdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (period_load),
        .clear_i (restart_i),
        .frac_i  (div_frac_i),
        .acc_o   (acc_q),
        .carry_o (carry)
    );

    fdiv_len_calc #(.INT_W(INT_W)) u_len (
        .div_int_i (div_int_i),
        .carry_i   (carry),
        .len_m1_o  (len_m1)
    );

    fdiv_down_cnt #(.W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (period_load),
        .dec_i      (cnt_dec),
        .load_val_i (len_m1),
        .cnt_o      (cnt_q),
        .is_one_o   (cnt_is_one)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = (len_m1 == '0) ? ST_EDGE : ST_WAIT;
        end else begin
            unique case (state_q)
                ST_EDGE: begin
                    if (run_i) begin
                        state_d = (len_m1 == '0) ? ST_EDGE : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (run_i && cnt_is_one) begin
                        state_d = ST_EDGE;
                    end
                end
                default: state_d = ST_EDGE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_EDGE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ST_EDGE: tick_o = run_i & ~restart_i;
            ST_WAIT: tick_o = 1'b0;
            default: tick_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
    parameter int CNT_W  = 17,
    parameter int FRAC_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              run_i,
    input logic              restart_i,
    input logic              tick_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [FRAC_W-1:0] acc_q
);

    p_tick_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !tick_o);

    p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> ($stable(cnt_q) && $stable(acc_q)));

    p_restart_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |-> !tick_o);

    p_count_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !restart_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && !restart_i) |=> $stable(acc_q));

    p_tick_at_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (cnt_q == '0));

endmodule

bind fdiv_top fdiv_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_fdiv_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .restart_i (restart_i),
    .tick_o    (tick_o),
    .cnt_q     (cnt_q),
    .acc_q     (acc_q)
);

// File: tb/fdiv_top_tb_top.sv
module fdiv_top_tb_top;

    localparam int CLK_P = 10;
    localparam int NVEC  = 8;
    // {integer, fraction, pulses to measure}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd1, 8'd0,   16'd8},
        {16'd2, 8'd0,   16'd8},
        {16'd7, 8'd0,   16'd4},
        {16'd3, 8'd128, 16'd16},
        {16'd2, 8'd255, 16'd256},
        {16'd5, 8'd1,   16'd256},
        {16'd1, 8'd64,  16'd16},
        {16'd0, 8'd0,   16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] div_int = 16'd1;
    logic [7:0]  div_frac = 8'd0;
    logic        tick;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    fdiv_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .run_i      (run),
        .restart_i  (restart),
        .div_int_i  (div_int),
        .div_frac_i (div_frac),
        .tick_o     (tick)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, sample shortly after
    task automatic cyc(input logic r, input logic rs, output logic t);
        @(negedge clk);
        run = r;
        restart = rs;
        #1;
        t = tick;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run = 1'b0;
        restart = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic longint exp_time(input longint n, input longint ie, input longint f);
        return n * ie + (n * f) / 256;
    endfunction

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic t;
        int   seen;

        // R4: reset state, first running cycle pulses regardless of divisor
        div_int = 16'd5;
        div_frac = 8'd0;
        do_reset();
        cyc(1'b0, 1'b0, t);
        check(t == 1'b0, "R5 idle after reset", t, 0);
        cyc(1'b1, 1'b0, t);
        check(t == 1'b1, "R4 first running cycle", t, 1);
        seen = 0;
        for (int i = 1; i <= 5; i++) begin
            cyc(1'b1, 1'b0, t);
            if (t) seen = i;
        end
        check(seen == 5, "R4 second pulse after INT", seen, 5);

        // R4: INT=1, FRAC=0 after reset pulses every cycle
        div_int = 16'd1;
        do_reset();
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b0, t);
            if (t) seen++;
        end
        check(seen == 6, "R4 every cycle at divisor 1", seen, 6);

        // R1/R2/R3: vector table, pulse times after a restart
        for (int v = 0; v < NVEC; v++) begin
            longint ie, f, n, got, i, last;
            ie = (VEC[v][39:24] == 16'd0) ? 65536 : longint'(VEC[v][39:24]);
            f = longint'(VEC[v][23:16]);
            n = longint'(VEC[v][15:0]);
            @(negedge clk);
            div_int = VEC[v][39:24];
            div_frac = VEC[v][23:16];
            cyc(1'b1, 1'b1, t);
            check(t == 1'b0, "R6 no pulse in restart cycle", t, 0);
            got = 0;
            i = 0;
            last = exp_time(n, ie, f);
            while (got < n && i < last + 4) begin
                i++;
                cyc(1'b1, 1'b0, t);
                if (t) begin
                    got++;
                    check(i == exp_time(got, ie, f),
                          (ie == 65536) ? "R2 zero integer period" :
                          (f == 0) ? "R1 integer spacing" : "R3 fractional spacing",
                          i, exp_time(got, ie, f));
                end
            end
            check(got == n, "R3 pulse count", got, n);
            if (n == 256) begin
                check(i == 256 * ie + f, "R3 256-pulse span", i, 256 * ie + f);
            end
        end

        // R5: pause mid-period, then complete remaining cycles
        @(negedge clk);
        div_int = 16'd4;
        div_frac = 8'd0;
        cyc(1'b1, 1'b1, t);
        cyc(1'b1, 1'b0, t);
        cyc(1'b1, 1'b0, t);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 1'b0, t);
            if (t) seen++;
        end
        check(seen == 0, "R5 no pulse while halted", seen, 0);
        cyc(1'b1, 1'b0, t);
        check(t == 1'b0, "R5 first resumed cycle", t, 0);
        cyc(1'b1, 1'b0, t);
        check(t == 1'b1, "R5 remaining period completes", t, 1);

        // R6: restart while halted, then run
        @(negedge clk);
        div_int = 16'd3;
        cyc(1'b1, 1'b0, t);
        cyc(1'b0, 1'b1, t);
        seen = 0;
        for (int i = 1; i <= 3; i++) begin
            cyc(1'b1, 1'b0, t);
            if (t && seen == 0) seen = i;
        end
        check(seen == 3, "R6 restart while halted", seen, 3);

        // R6: restart mid-period re-phases immediately
        @(negedge clk);
        div_int = 16'd6;
        cyc(1'b1, 1'b1, t);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, t);
        cyc(1'b1, 1'b1, t);
        seen = 0;
        for (int i = 1; i <= 6; i++) begin
            cyc(1'b1, 1'b0, t);
            if (t && seen == 0) seen = i;
        end
        check(seen == 6, "R6 mid-period restart", seen, 6);

        // R6: restart suppresses a pulse at divisor 1
        @(negedge clk);
        div_int = 16'd1;
        cyc(1'b1, 1'b1, t);
        cyc(1'b1, 1'b0, t);
        cyc(1'b1, 1'b1, t);
        check(t == 1'b0, "R6 restart masks pulse", t, 0);
        cyc(1'b1, 1'b0, t);
        check(t == 1'b1, "R6 pulse after restart at divisor 1", t, 1);

        // R7: divisor change mid-period applies to the next period only
        @(negedge clk);
        div_int = 16'd8;
        cyc(1'b1, 1'b1, t);
        seen = 0;
        for (int i = 1; i <= 10; i++) begin
            if (i == 3) div_int = 16'd2;
            cyc(1'b1, 1'b0, t);
            if (t) begin
                if (seen == 0) begin
                    check(i == 8, "R7 current period unchanged", i, 8);
                    seen = i;
                end else begin
                    check(i == 10, "R7 new divisor next period", i, 10);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule